// File: doc/BRIEF.md
# Dual-Select Static RAM with Output Disable

This block is a small word-addressed static memory. It has separate data-in and data-out buses and a single address bus. Two select inputs of opposite sense gate all access, so several banks can share one address space with very little decode logic. A read/write control chooses the operation. An output-disable input can silence the output at any time, independent of selection. That lets the data-in and data-out buses be tied together on one shared bus.

A floating output is modelled as a data bus plus an output-enable flag. When the flag is low the data bus is driven to zero, and a wrapper may map the pair onto a tri-state driver. Writes are committed on the rising clock edge. Reads are combinational from the stored words. While the active-low reset is asserted, no write reaches the array. The array itself is never cleared, so its contents are undefined until written.

Top module: `dual_sel_ram`

## Requirements
- R1: The array holds 2^ADDR_W words of DATA_W bits (256 x 4 by default), and every address stores its word independently of all others.
- R2: The block is selected only when sel_lo_n is 0 and sel_hi is 1; the other three combinations of the pair deselect it.
- R3: While deselected, dout_en is 0 and dout is all zeros, whatever the other inputs are.
- R4: While deselected, a write request (rd_wr_n = 0) changes no stored word.
- R5: While out_dis is 1, dout_en is 0 and dout is all zeros, regardless of selects and rd_wr_n.
- R6: When selected with out_dis = 0 and rd_wr_n = 1, dout_en is 1 and dout equals the word stored at addr.
- R7: When selected with out_dis = 0 and rd_wr_n = 0, dout_en is 1 and dout equals din (not the old stored word).
- R8: When selected with out_dis = 1 and rd_wr_n = 0, the write still takes place while dout_en stays 0.
- R9: A write is committed at the rising clk edge on which the write condition holds; a read of that address in the following cycle returns the new word.
- R10: While rst_n is 0, no stored word changes even if a selected write is requested.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; writes commit on its rising edge |
| rst_n | input | 1 | Active-low reset; blocks writes while low |
| addr | input | ADDR_W | Word address for both read and write |
| din | input | DATA_W | Write data |
| sel_lo_n | input | 1 | Active-low select |
| sel_hi | input | 1 | Active-high select |
| out_dis | input | 1 | Output disable, 1 floats the output |
| rd_wr_n | input | 1 | 1 = read, 0 = write |
| dout | output | DATA_W | Output data, zero when not enabled |
| dout_en | output | 1 | Output enable; 0 models high impedance |

## Verification
The bench fills every address with an arithmetic pattern and reads each word back. A decoder that aliased address bits would return a neighbour's word. Every deselecting select pair is then driven together with a write of inverted data, and a later full read-back exposes a design that wrote while in standby or treated one select with the wrong polarity. A write with the output disabled is checked both for a floating output and for the stored result, which catches designs that tie the write to the output enable. The bench also checks that write data is echoed during a write rather than the old word, that a written word appears only after the clock edge, and that a write requested during reset is dropped.

// File: rtl/dual_sel_ram_pkg.sv
package dual_sel_ram_pkg;
    localparam int unsigned DEF_ADDR_W = 8;
    localparam int unsigned DEF_DATA_W = 4;

    typedef enum logic [1:0] {
        OP_STANDBY = 2'd0,
        OP_READ    = 2'd1,
        OP_WRITE   = 2'd2
    } op_mode_e;
endpackage

// File: rtl/dual_sel_ram_ctrl.sv
module dual_sel_ram_ctrl
    import dual_sel_ram_pkg::*;
#(
    parameter int unsigned DATA_W = DEF_DATA_W
) (
    input  logic              rst_n,
    input  logic              sel_lo_n,
    input  logic              sel_hi,
    input  logic              out_dis,
    input  logic              rd_wr_n,
    input  logic [DATA_W-1:0] din,
    input  logic [DATA_W-1:0] rd_data,
    output logic              wr_en,
    output logic [DATA_W-1:0] dout,
    output logic              dout_en
);
    op_mode_e mode;

    always_comb begin
        if (sel_lo_n || !sel_hi) mode = OP_STANDBY;
        else if (rd_wr_n)        mode = OP_READ;
        else                     mode = OP_WRITE;
    end

    always_comb begin
        wr_en   = rst_n && (mode == OP_WRITE);
        dout_en = (mode != OP_STANDBY) && !out_dis;
        dout    = '0;
        if (dout_en) begin
            dout = (mode == OP_WRITE) ? din : rd_data;
        end
    end
endmodule

// File: rtl/dual_sel_ram_array.sv
module dual_sel_ram_array
    import dual_sel_ram_pkg::*;
#(
    parameter int unsigned ADDR_W = DEF_ADDR_W,
    parameter int unsigned DATA_W = DEF_DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data
);
    localparam int unsigned DEPTH = 1 << ADDR_W;

    typedef logic [DATA_W-1:0] word_t;

    word_t mem_d [DEPTH];
    word_t mem_q [DEPTH];

    always_comb begin
        mem_d = mem_q;
        if (wr_en) begin
            mem_d[addr] = wr_data;
        end
    end

    always_ff @(posedge clk) begin
        mem_q <= mem_d;
    end

    assign rd_data = mem_q[addr];

    // R9
    wr_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (mem_q[$past(addr)] == $past(wr_data)));

    // R4
    no_write_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> (mem_q[$past(addr)] == $past(mem_q[addr])));
endmodule

// File: rtl/dual_sel_ram.sv
module dual_sel_ram
    import dual_sel_ram_pkg::*;
#(
    parameter int unsigned ADDR_W = DEF_ADDR_W,
    parameter int unsigned DATA_W = DEF_DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    input  logic              sel_lo_n,
    input  logic              sel_hi,
    input  logic              out_dis,
    input  logic              rd_wr_n,
    output logic [DATA_W-1:0] dout,
    output logic              dout_en
);
    logic              wr_en;
    logic [DATA_W-1:0] rd_data;

    dual_sel_ram_ctrl #(.DATA_W(DATA_W)) u_ctrl (
        .rst_n   (rst_n),
        .sel_lo_n(sel_lo_n),
        .sel_hi  (sel_hi),
        .out_dis (out_dis),
        .rd_wr_n (rd_wr_n),
        .din     (din),
        .rd_data (rd_data),
        .wr_en   (wr_en),
        .dout    (dout),
        .dout_en (dout_en)
    );

    dual_sel_ram_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .addr   (addr),
        .wr_data(din),
        .rd_data(rd_data)
    );

    // R3
    standby_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_lo_n || !sel_hi) |-> (!dout_en && dout == '0));

    // R5
    out_dis_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_dis |-> (!dout_en && dout == '0));

    // R7
    wr_echo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_lo_n && sel_hi && !out_dis && !rd_wr_n) |-> (dout_en && dout == din));

    // R6
    rd_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_lo_n && sel_hi && !out_dis && rd_wr_n) |-> dout_en);

    // R8
    hidden_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_lo_n && sel_hi && out_dis && !rd_wr_n) |-> (wr_en && !dout_en));
endmodule

// File: tb/dual_sel_ram_bench.sv
module dual_sel_ram_bench;
    localparam int AW = 8;
    localparam int DW = 4;
    localparam int N  = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] din = '0;
    logic          sel_lo_n = 1'b1;
    logic          sel_hi = 1'b0;
    logic          out_dis = 1'b0;
    logic          rd_wr_n = 1'b1;
    logic [DW-1:0] dout;
    logic          dout_en;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    dual_sel_ram u_dual_sel_ram (
        .clk(clk), .rst_n(rst_n), .addr(addr), .din(din),
        .sel_lo_n(sel_lo_n), .sel_hi(sel_hi), .out_dis(out_dis),
        .rd_wr_n(rd_wr_n), .dout(dout), .dout_en(dout_en)
    );

    function automatic logic [DW-1:0] pat_a(int a);
        return DW'((a * 7 + 3) % 16);
    endfunction

    function automatic logic [DW-1:0] pat_b(int a);
        return DW'((a * 5 + 9) % 16);
    endfunction

    task automatic check(string req, logic [DW:0] act, logic [DW:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual en/data=%b expected=%b", req, act, exp);
        end
    endtask

    // drive at negedge, sample combinational outputs 2 ns later
    task automatic drive(logic s_n, logic s, logic od, logic rw, int a, logic [DW-1:0] d);
        @(negedge clk);
        sel_lo_n = s_n; sel_hi = s; out_dis = od; rd_wr_n = rw;
        addr = AW'(a); din = d;
        #2;
    endtask

    initial begin
        // reset state
        drive(1, 0, 0, 1, 0, 0);
        check("R3 reset", {dout_en, dout}, {1'b0, 4'h0});
        drive(0, 1, 0, 1, 0, 0);
        rst_n = 1'b1;

        // R7/R1: fill all addresses, output echoes din
        for (int a = 0; a < N; a++) begin
            drive(0, 1, 0, 0, a, pat_a(a));
            check("R7 write echo", {dout_en, dout}, {1'b1, pat_a(a)});
        end
        // R1/R6: read back all
        for (int a = 0; a < N; a++) begin
            drive(0, 1, 0, 1, a, ~pat_a(a));
            check("R6 R1 read", {dout_en, dout}, {1'b1, pat_a(a)});
        end

        // R2/R3/R4: each deselecting pair with a write of inverted data
        for (int c = 0; c < 3; c++) begin
            for (int a = 0; a < N; a += 3) begin
                logic sn, sh;
                sn = (c != 1); sh = (c == 0);
                drive(sn, sh, a[0], 0, a, ~pat_a(a));
                check("R2 R3 standby", {dout_en, dout}, {1'b0, 4'h0});
            end
        end
        for (int a = 0; a < N; a++) begin
            drive(0, 1, 0, 1, a, 0);
            check("R4 standby no write", {dout_en, dout}, {1'b1, pat_a(a)});
        end

        // R5: output disable on read
        for (int a = 0; a < 16; a++) begin
            drive(0, 1, 1, 1, a, 0);
            check("R5 out_dis read", {dout_en, dout}, {1'b0, 4'h0});
        end

        // R8: hidden write with output disabled
        for (int a = 0; a < N; a++) begin
            drive(0, 1, 1, 0, a, pat_b(a));
            check("R8 hidden write hiz", {dout_en, dout}, {1'b0, 4'h0});
        end
        for (int a = 0; a < N; a++) begin
            drive(0, 1, 0, 1, a, 0);
            check("R8 hidden write stored", {dout_en, dout}, {1'b1, pat_b(a)});
        end

        // R9: new word visible only after the edge
        drive(0, 1, 0, 1, 10, 0);
        check("R9 old word", {dout_en, dout}, {1'b1, pat_b(10)});
        drive(0, 1, 0, 0, 10, ~pat_b(10));
        check("R9 R7 echo", {dout_en, dout}, {1'b1, ~pat_b(10)});
        drive(0, 1, 0, 1, 10, 0);
        check("R9 new word", {dout_en, dout}, {1'b1, ~pat_b(10)});

        // R10: write requested in reset is dropped
        drive(0, 1, 0, 1, 20, 0);
        rst_n = 1'b0;
        drive(0, 1, 0, 0, 20, ~pat_b(20));
        drive(0, 1, 0, 0, 20, ~pat_b(20));
        drive(0, 1, 0, 1, 20, 0);
        rst_n = 1'b1;
        drive(0, 1, 0, 1, 20, 0);
        check("R10 reset blocks write", {dout_en, dout}, {1'b1, pat_b(20)});

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule